// File: doc/BRIEF.md
# DMA Bus Handover Clock Aligner

This block decides when a processor gives the shared bus to a DMA engine and when it gets the bus back, counted in master clocks. Software starts a transfer by writing the DMA-enable register. The CPU does not stop on that write. It first completes one more bus cycle, which lasts 6, 8 or 12 master clocks, so the opcode of the next instruction is fetched before the bus changes hands. The block records how long that extra cycle was.

The block then halts the CPU and pads the time up to an 8-clock boundary. It runs the transfer in steps of 8 clocks, one step per byte. When the transfer ends, it pads the time again, this time to a multiple of the recorded cycle length, and then releases the CPU.

For the first CPU cycle after the release, the block raises an interrupt-inhibit flag, which blocks the interrupt check in that cycle. Addresses and data of the transfer are handled elsewhere.

Top module: `dmaseq_align`

## Requirements
- R1: After reset `cpu_halt`, `xfer_en` and `irq_inhibit` are all low.
- R2: A write strobe (`en_wr`) seen while idle arms the block. `cpu_halt` rises in the first clock after the next `cpu_cyc_end`, that is, after one more complete CPU cycle. A `cpu_cyc_end` in the same clock as the write does not count as that cycle.
- R3: Clock count means master clocks since reset, taken modulo 24. `xfer_en` first rises in the first halted clock whose count is a multiple of 8. If the first halted clock is already a multiple of 8, `xfer_en` rises there with no wait.
- R4: `xfer_en` stays high for 8 × `xfer_bytes` clocks, using the value of `xfer_bytes` latched at the write. A byte count of zero gives no transfer clocks.
- R5: If `xfer_done` is high during a step, the transfer ends at the end of that step.
- R6: `cpu_halt` falls in the first clock, at or after the end of the transfer, whose count is a multiple of the captured length of the extra cycle. The captured length is 6 for `cpu_cyc_len`=6, 12 for 12, and 8 for any other value. If the count is already on that grid, there is no wait.
- R7: `irq_inhibit` rises in the clock where `cpu_halt` falls. It stays high up to and including the clock of the next `cpu_cyc_end`, then drops. It is never high together with `cpu_halt`.
- R8: A write strobe that arrives while a sequence is in progress has no effect. No second halt follows it.
- R9: `xfer_en` is high only while `cpu_halt` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_wr | input | 1 | Strobe for a write to the DMA-enable register |
| cpu_cyc_end | input | 1 | High in the last master clock of each CPU bus cycle |
| cpu_cyc_len | input | 4 | Length in master clocks of the CPU cycle now running |
| xfer_bytes | input | CNT_W | Number of bytes to move, latched at the write |
| xfer_done | input | 1 | Early end request from the transfer engine |
| cpu_halt | output | 1 | Stalls the CPU |
| xfer_en | output | 1 | Lets the transfer engine run |
| irq_inhibit | output | 1 | Blocks the interrupt check in the first CPU cycle after DMA |

## Verification
The hardest case to reach is one where both pads are nonzero together with every captured cycle length. Both pads depend on the clock count at the moment the extra cycle ends.

To reach it, the bench changes the number of idle clocks before each write, so the extra cycle ends at many different counts. For each run it derives the expected rise and fall clocks from that end time. An early-done pulse in the middle of a step and a write strobe issued during the extra cycle cover the remaining orderings.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;

   typedef enum logic [2:0] {
      S_IDLE, S_ARM, S_PRE, S_XFER, S_POST, S_INH
   } seq_st_t;

   typedef enum logic [1:0] {LEN6, LEN8, LEN12} clen_t;

   function automatic clen_t enc_len(input logic [3:0] l);
      case (l)
         4'd6:    return LEN6;
         4'd12:   return LEN12;
         default: return LEN8;
      endcase
   endfunction

   // true when clock count ph sits on the grid of the recorded cycle length
   function automatic logic on_grid(input int ph, input clen_t c);
      case (c)
         LEN6:    return (ph % 6) == 0;
         LEN12:   return (ph % 12) == 0;
         default: return (ph % 8) == 0;
      endcase
   endfunction

endpackage

// File: rtl/dmaseq_phase.sv
module dmaseq_phase #(
   parameter int MOD = 24,
   parameter int W   = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] ph_nx
);
   logic [W-1:0] ph;

   assign ph_nx = (ph == W'(MOD - 1)) ? '0 : ph + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph <= '0;
      else        ph <= ph_nx;
   end
endmodule

// File: rtl/dmaseq_step.sv
module dmaseq_step #(
   parameter int STEP  = 8,
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   output logic             step_last,
   output logic [CNT_W-1:0] steps_done
);
   localparam int SW = $clog2(STEP);

   logic [SW-1:0] sub;

   assign step_last = run && (sub == SW'(STEP - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub        <= '0;
         steps_done <= '0;
      end else if (!run) begin
         sub        <= '0;
         steps_done <= '0;
      end else begin
         sub <= step_last ? '0 : sub + 1'b1;
         if (step_last) steps_done <= steps_done + 1'b1;
      end
   end
endmodule

// File: rtl/dmaseq_align.sv
module dmaseq_align
   import dmaseq_pkg::*;
#(
   parameter int CNT_W      = 8,
   parameter int STEP_CLKS  = 8,
   parameter int PH_MOD     = 24,
   parameter bit HONOR_DONE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_wr,
   input  logic             cpu_cyc_end,
   input  logic [3:0]       cpu_cyc_len,
   input  logic [CNT_W-1:0] xfer_bytes,
   input  logic             xfer_done,
   output logic             cpu_halt,
   output logic             xfer_en,
   output logic             irq_inhibit
);
   localparam int PH_W = $clog2(PH_MOD);

   if (PH_MOD % 24 != 0) begin : g_bad_mod
      $error("PH_MOD must be a multiple of 6, 8 and 12");
   end
   if (PH_MOD % STEP_CLKS != 0 || STEP_CLKS < 2) begin : g_bad_step
      $error("STEP_CLKS must be at least 2 and divide PH_MOD");
   end

   seq_st_t          st, st_n;
   clen_t            len_q, len_n, cap;
   logic [CNT_W-1:0] bytes_q, bytes_n, steps_done;
   logic [PH_W-1:0]  ph_nx;
   logic             step_last, done_seen, done_req, ent_al, ext_al;

   dmaseq_phase #(.MOD(PH_MOD), .W(PH_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .ph_nx(ph_nx)
   );

   dmaseq_step #(.STEP(STEP_CLKS), .CNT_W(CNT_W)) u_step (
      .clk(clk), .rst_n(rst_n), .run(st == S_XFER),
      .step_last(step_last), .steps_done(steps_done)
   );

   if (HONOR_DONE) begin : g_done
      assign done_req = xfer_done | done_seen;
   end else begin : g_nodone
      assign done_req = 1'b0;
   end

   assign cap    = enc_len(cpu_cyc_len);
   assign ent_al = (int'(ph_nx) % STEP_CLKS) == 0;
   assign ext_al = on_grid(int'(ph_nx), len_n);

   always_comb begin
      st_n    = st;
      len_n   = len_q;
      bytes_n = bytes_q;
      case (st)
         S_IDLE: if (en_wr) begin
            st_n    = S_ARM;
            bytes_n = xfer_bytes;
         end
         S_ARM: if (cpu_cyc_end) begin
            len_n = cap;
            if (!ent_al)              st_n = S_PRE;
            else if (bytes_q == '0)   st_n = ext_al ? S_INH : S_POST;
            else                      st_n = S_XFER;
         end
         S_PRE: begin
            if (!ent_al)              st_n = S_PRE;
            else if (bytes_q == '0)   st_n = ext_al ? S_INH : S_POST;
            else                      st_n = S_XFER;
         end
         S_XFER: if (step_last &&
                     (steps_done == CNT_W'(bytes_q - 1'b1) || done_req))
            st_n = ext_al ? S_INH : S_POST;
         S_POST: if (ext_al) st_n = S_INH;
         S_INH:  if (cpu_cyc_end) st_n = S_IDLE;
         default: st_n = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         len_q     <= LEN8;
         bytes_q   <= '0;
         done_seen <= 1'b0;
      end else begin
         st        <= st_n;
         len_q     <= len_n;
         bytes_q   <= bytes_n;
         done_seen <= (st == S_XFER) && !step_last && (done_seen || xfer_done);
      end
   end

   assign cpu_halt    = (st == S_PRE) || (st == S_XFER) || (st == S_POST);
   assign xfer_en     = (st == S_XFER);
   assign irq_inhibit = (st == S_INH);
endmodule

// File: rtl/dmaseq_chk.sv
module dmaseq_chk #(
   parameter int STEP = 8
) (
   input logic clk,
   input logic rst_n,
   input logic cpu_cyc_end,
   input logic cpu_halt,
   input logic xfer_en,
   input logic irq_inhibit
);
   int c_mod;
   int xrun;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_mod <= 0;
         xrun  <= 0;
      end else begin
         c_mod <= (c_mod + 1) % STEP;
         xrun  <= xfer_en ? xrun + 1 : 0;
      end
   end

   // R2
   halt_after_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_halt) |-> $past(cpu_cyc_end));

   // R3
   xfer_on_grid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(xfer_en) |-> (c_mod == 0));

   // R4
   xfer_whole_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(xfer_en) |-> (xrun % STEP == 0));

   // R7
   inhibit_follows_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cpu_halt) |-> irq_inhibit);

   // R7
   inhibit_not_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_inhibit && cpu_halt));

   // R9
   xfer_needs_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_en |-> cpu_halt);
endmodule

bind dmaseq_align dmaseq_chk #(.STEP(STEP_CLKS)) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_cyc_end(cpu_cyc_end),
   .cpu_halt(cpu_halt), .xfer_en(xfer_en), .irq_inhibit(irq_inhibit)
);

// File: tb/sim_dmaseq_align.sv
module sim_dmaseq_align;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en_wr = 1'b0;
   logic       cpu_cyc_end = 1'b0;
   logic [3:0] cpu_cyc_len = 4'd8;
   logic [7:0] xfer_bytes = 8'd0;
   logic       xfer_done = 1'b0;
   logic       cpu_halt, xfer_en, irq_inhibit;

   int errors = 0, checks = 0, tc = 0, last_end = 0;
   int h_rise, h_fall, x_first, x_cnt, i_first, i_last, h_cnt;
   logic p_h = 1'b0;

   // idle clocks, extra-cycle length, byte count
   localparam logic [23:0] VEC [8] = '{
      {8'd0, 8'd8, 8'd2},  {8'd3, 8'd6, 8'd1},  {8'd5, 8'd12, 8'd3},
      {8'd1, 8'd6, 8'd4},  {8'd7, 8'd12, 8'd0}, {8'd2, 8'd8, 8'd0},
      {8'd11, 8'd6, 8'd2}, {8'd4, 8'd12, 8'd1}
   };

   always #4 clk = ~clk;

   dmaseq_align u0 (
      .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .cpu_cyc_end(cpu_cyc_end),
      .cpu_cyc_len(cpu_cyc_len), .xfer_bytes(xfer_bytes), .xfer_done(xfer_done),
      .cpu_halt(cpu_halt), .xfer_en(xfer_en), .irq_inhibit(irq_inhibit)
   );

   always @(posedge clk) if (rst_n) tc <= tc + 1;

   always @(negedge clk) if (rst_n) begin
      if (cpu_halt && !p_h && h_rise < 0) h_rise = tc;
      if (!cpu_halt && p_h && h_fall < 0) h_fall = tc;
      if (xfer_en) begin
         if (x_first < 0) x_first = tc;
         x_cnt++;
      end
      if (irq_inhibit) begin
         if (i_first < 0) i_first = tc;
         i_last = tc;
      end
      if (cpu_halt) h_cnt++;
      p_h = cpu_halt;
   end

   task automatic clear_mon();
      h_rise = -1; h_fall = -1; x_first = -1; x_cnt = 0;
      i_first = -1; i_last = -1; h_cnt = 0;
   endtask

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // one CPU bus cycle; optional write strobe on clock index wr_at
   task automatic cpu_cycle(input int len, input int wr_at);
      for (int i = 0; i < len; i++) begin
         cpu_cyc_len = 4'(len);
         cpu_cyc_end = (i == len - 1);
         en_wr       = (i == wr_at);
         if (i == len - 1) last_end = tc;
         @(negedge clk);
      end
      cpu_cyc_end = 1'b0;
      en_wr       = 1'b0;
   endtask

   function automatic int ceilm(input int t, input int m);
      return ((t + m - 1) / m) * m;
   endfunction

   task automatic check_run(input int len, input int nsteps, input int xclk);
      int t0, ts, te, tr;
      t0 = last_end + 1;
      ts = ceilm(t0, 8);
      te = ts + xclk;
      tr = ceilm(te, (len == 6) ? 6 : (len == 12) ? 12 : 8);
      chk("R2 halt rise", h_rise, (tr > t0) ? t0 : -1);
      chk("R3 xfer start", x_first, (nsteps > 0) ? ts : -1);
      chk("R4 xfer clocks", x_cnt, xclk);
      chk("R6 halt release", h_fall, (tr > t0) ? tr : -1);
      chk("R7 inhibit start", i_first, tr);
      chk("R7 inhibit end", i_last, tr + 7);
   endtask

   initial begin
      int wd;
      wd = 0;
      while (wd < 150000) begin
         @(posedge clk);
         wd++;
      end
      errors++;
      $display("FAIL watchdog: actual %0d expected 0", wd);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      clear_mon();
      repeat (3) @(negedge clk);
      // R1
      chk("R1 halt", int'(cpu_halt), 0);
      chk("R1 xfer", int'(xfer_en), 0);
      chk("R1 inhibit", int'(irq_inhibit), 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < 8; v++) begin
         int idle, len, nb, tstart;
         idle = int'(VEC[v][23:16]);
         len  = int'(VEC[v][15:8]);
         nb   = int'(VEC[v][7:0]);
         repeat (idle) @(negedge clk);
         clear_mon();
         xfer_bytes = 8'(nb);
         cpu_cycle(8, 7);
         cpu_cycle(len, -1);
         tstart = last_end;
         while (cpu_halt) @(negedge clk);
         last_end = tstart;
         cpu_cycle(8, -1);
         @(negedge clk);
         last_end = tstart;
         check_run(len, nb, 8 * nb);
      end

      // R5: early done in the middle of the second step
      begin
         int tstart;
         clear_mon();
         xfer_bytes = 8'd6;
         cpu_cycle(8, 7);
         cpu_cycle(6, -1);
         tstart = last_end;
         while (!xfer_en) @(negedge clk);
         repeat (10) @(negedge clk);
         xfer_done = 1'b1;
         @(negedge clk);
         xfer_done = 1'b0;
         while (cpu_halt) @(negedge clk);
         cpu_cycle(8, -1);
         @(negedge clk);
         last_end = tstart;
         chk("R5 early done clocks", x_cnt, 16);
         check_run(6, 2, 16);
      end

      // R8: write strobe during the extra cycle is ignored
      begin
         int tstart;
         repeat (2) @(negedge clk);
         clear_mon();
         xfer_bytes = 8'd1;
         cpu_cycle(8, 7);
         cpu_cycle(12, 0);
         tstart = last_end;
         while (cpu_halt) @(negedge clk);
         cpu_cycle(8, -1);
         @(negedge clk);
         last_end = tstart;
         check_run(12, 1, 8);
         clear_mon();
         for (int k = 0; k < 3; k++) cpu_cycle(8, -1);
         repeat (20) @(negedge clk);
         chk("R8 no second halt", h_cnt, 0);
         chk("R8 no second inhibit", i_first, -1);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule